// File: doc/BRIEF.md
# Doorbell to MSI Write Generator

This block sits between two hosts joined by a bridge. One host rings a doorbell by writing into the doorbell part of an aperture. The block turns that write into one message-signalled interrupt write aimed at the other host. The doorbell aperture is cut into equal slots, and each slot belongs to one interrupt vector. The slot size is a power of two that software programs as a shift amount. The slot index is the write offset shifted right by that amount. The data the host writes carries no meaning: only the slot that was hit decides what gets sent.

Each vector has its own translation entry, which holds a 64-bit target address and a 32-bit data word. These entries live in a small table that the block fills only when the configure command runs. On that command the loader walks the vector source entries from 0 up to the requested count, one per cycle. In per-vector mode it copies each entry's own address and data. In shared mode every entry gets the address of vector 0, and entry n gets vector 0's data plus n. Both MSI (one shared address) and MSI-X (per-vector addresses) therefore use the same path to raise an interrupt. A doorbell that falls outside the configured vectors is dropped and sets a sticky error flag. At most one outbound request is in flight at any time, and it uses a valid/ready handshake.

Top module: `db_msi_gen`

## Requirements
- R1: After reset `msi_valid` is 0, `db_err` is 0, `cfg_busy` is 0 and `db_ready` is 1.
- R2: A doorbell write at byte offset `off` hits slot `off >> db_slot_shift`. In per-vector mode its outbound write carries the address and data that the source gave for that vector index.
- R3: In shared mode (`cfg_shared`=1) every slot n sends the address of source vector 0, and its data is source vector 0's data plus n.
- R4: A configure pulse with count N loads min(N, NUM_DB) entries, one per cycle, and presents each index on `src_idx`. `cfg_busy` is high for exactly that many cycles. `db_ready` stays low while it is high.
- R5: A doorbell to a slot at or beyond the configured count is dropped, and this includes any doorbell before the first configure and any doorbell after a configure with count 0. A dropped doorbell makes no outbound write and sets `db_err`. `db_err` stays set until reset.
- R6: An accepted hit raises `msi_valid` on the second clock edge after acceptance. Address and data then hold steady until `msi_ready` is seen. Each hit produces exactly one request.
- R7: `db_ready` falls on the clock edge that accepts a hit. It rises again only after the edge on which the outbound handshake completes.
- R8: The doorbell write payload `db_wdata` has no effect on the outbound address or data.
- R9: A new configure with a smaller count retires the higher slots, so doorbells to them now take the drop path.
- R10: Changing `db_slot_shift` changes which slot a given offset selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Configure-doorbell command pulse |
| cfg_count | input | 6 | Requested number of vectors |
| cfg_shared | input | 1 | 1: one shared address, data incremented per vector |
| cfg_busy | output | 1 | Table load in progress |
| src_idx | output | 5 | Vector index being read from the source |
| src_addr | input | 64 | Source target address for `src_idx` |
| src_data | input | 32 | Source data word for `src_idx` |
| db_slot_shift | input | 4 | log2 of the slot size in bytes |
| db_valid | input | 1 | Doorbell write present |
| db_ready | output | 1 | Doorbell write accepted when high with `db_valid` |
| db_offset | input | 16 | Byte offset inside the doorbell aperture |
| db_wdata | input | 32 | Doorbell payload (ignored) |
| msi_valid | output | 1 | Outbound interrupt write pending |
| msi_ready | input | 1 | Outbound write taken |
| msi_addr | output | 64 | Outbound write address |
| msi_data | output | 32 | Outbound write data |
| db_err | output | 1 | Sticky flag: a doorbell was dropped |

## Verification
The bench aims at the edges of the slot decode. It uses the last byte of a slot, the first slot past the configured count, and the same offset under two shift values, which catches an off-by-one compare or a decode that ignores the shift. It reloads with a count above the table depth and with count 0. A design that fails to clamp would keep the loader busy too long, and one that forgets to retire old entries would still fire stale vectors. Shared mode is checked on the last vector, where a missing data increment or a per-vector address fetch shows at once. It also holds `msi_ready` low, which exposes an output that changes or duplicates its request under back-pressure.

// File: rtl/db_msi_pkg.sv
package db_msi_pkg;
  localparam int MSI_ADDR_W = 64;
  localparam int MSI_DATA_W = 32;

  typedef struct packed {
    logic [MSI_ADDR_W-1:0] addr;
    logic [MSI_DATA_W-1:0] data;
  } msi_entry_t;
endpackage

// File: rtl/db_vec_loader.sv
module db_vec_loader
  import db_msi_pkg::*;
#(
  parameter int NUM_DB = 32,
  localparam int IDX_W = $clog2(NUM_DB),
  localparam int CNT_W = $clog2(NUM_DB + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [CNT_W-1:0]      req_count,
  input  logic                  shared_mode,
  input  logic [MSI_ADDR_W-1:0] src_addr,
  input  logic [MSI_DATA_W-1:0] src_data,
  output logic [IDX_W-1:0]      src_idx,
  output logic                  busy,
  output logic                  wr_en,
  output logic [IDX_W-1:0]      wr_idx,
  output msi_entry_t            wr_entry,
  output logic [CNT_W-1:0]      live_count
);
  logic [CNT_W-1:0]      clamped;
  logic [CNT_W-1:0]      target_q;
  logic [IDX_W-1:0]      idx_q;
  logic [MSI_ADDR_W-1:0] base_addr_q;
  logic [MSI_DATA_W-1:0] base_data_q;
  logic                  first;
  logic                  last;

  assign clamped = (req_count > CNT_W'(NUM_DB)) ? CNT_W'(NUM_DB) : req_count;
  assign first   = (idx_q == '0);
  assign last    = (CNT_W'(idx_q) == target_q - CNT_W'(1));

  always_comb begin
    wr_entry.addr = src_addr;
    wr_entry.data = src_data;
    if (shared_mode) begin
      wr_entry.addr = first ? src_addr : base_addr_q;
      wr_entry.data = (first ? src_data : base_data_q) + MSI_DATA_W'(idx_q);
    end
  end

  assign src_idx = idx_q;
  assign wr_en   = busy;
  assign wr_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      idx_q       <= '0;
      target_q    <= '0;
      live_count  <= '0;
      base_addr_q <= '0;
      base_data_q <= '0;
    end else if (busy) begin
      if (first) begin
        base_addr_q <= src_addr;
        base_data_q <= src_data;
      end
      if (last) begin
        busy       <= 1'b0;
        live_count <= target_q;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end else if (start) begin
      idx_q      <= '0;
      target_q   <= clamped;
      live_count <= '0;
      busy       <= (clamped != '0);
    end
  end

  // R4
  load_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (CNT_W'(idx_q) < target_q));
  // R9
  count_retired_while_loading_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (live_count == '0));
endmodule

// File: rtl/db_vec_ram.sv
module db_vec_ram
  import db_msi_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  msi_entry_t       wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output msi_entry_t       rdata
);
  msi_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/db_slot_decode.sv
module db_slot_decode #(
  parameter int NUM_DB  = 32,
  parameter int OFF_W   = 16,
  parameter int SHIFT_W = 4,
  localparam int IDX_W = $clog2(NUM_DB),
  localparam int CNT_W = $clog2(NUM_DB + 1)
) (
  input  logic [OFF_W-1:0]   offset,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [CNT_W-1:0]   live_count,
  output logic [IDX_W-1:0]   slot,
  output logic               hit
);
  logic [OFF_W-1:0] slot_full;

  assign slot_full = offset >> shift;
  assign hit       = (slot_full < OFF_W'(live_count));
  assign slot      = slot_full[IDX_W-1:0];
endmodule

// File: rtl/db_msi_issuer.sv
module db_msi_issuer
  import db_msi_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_busy,
  input  logic                  db_valid,
  input  logic                  hit,
  input  msi_entry_t            ram_q,
  input  logic                  msi_ready,
  output logic                  db_ready,
  output logic                  rd_en,
  output logic                  msi_valid,
  output logic [MSI_ADDR_W-1:0] msi_addr,
  output logic [MSI_DATA_W-1:0] msi_data,
  output logic                  db_err
);
  logic stage_vld;
  logic accept;

  assign db_ready = !load_busy && !stage_vld && !msi_valid;
  assign accept   = db_valid && db_ready;
  assign rd_en    = accept && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_vld <= 1'b0;
      msi_valid <= 1'b0;
      msi_addr  <= '0;
      msi_data  <= '0;
      db_err    <= 1'b0;
    end else begin
      if (accept && !hit) db_err <= 1'b1;
      if (stage_vld) begin
        stage_vld <= 1'b0;
        msi_valid <= 1'b1;
        msi_addr  <= ram_q.addr;
        msi_data  <= ram_q.data;
      end else if (rd_en) begin
        stage_vld <= 1'b1;
      end else if (msi_valid && msi_ready) begin
        msi_valid <= 1'b0;
      end
    end
  end

  // R6
  msi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_addr) && $stable(msi_data)));
  // R7
  ready_low_pending_chk: assert property (@(posedge clk) disable iff (rst)
    msi_valid |-> !db_ready);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    db_err |=> db_err);
  // R4
  no_accept_loading_chk: assert property (@(posedge clk) disable iff (rst)
    load_busy |-> !db_ready);
  // R6
  single_request_chk: assert property (@(posedge clk) disable iff (rst)
    (msi_valid && msi_ready) |=> !msi_valid);
endmodule

// File: rtl/db_msi_gen.sv
module db_msi_gen
  import db_msi_pkg::*;
#(
  parameter int NUM_DB  = 32,
  parameter int OFF_W   = 16,
  parameter int SHIFT_W = 4,
  localparam int IDX_W = $clog2(NUM_DB),
  localparam int CNT_W = $clog2(NUM_DB + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_start,
  input  logic [CNT_W-1:0]      cfg_count,
  input  logic                  cfg_shared,
  output logic                  cfg_busy,
  output logic [IDX_W-1:0]      src_idx,
  input  logic [MSI_ADDR_W-1:0] src_addr,
  input  logic [MSI_DATA_W-1:0] src_data,
  input  logic [SHIFT_W-1:0]    db_slot_shift,
  input  logic                  db_valid,
  output logic                  db_ready,
  input  logic [OFF_W-1:0]      db_offset,
  input  logic [31:0]           db_wdata,
  output logic                  msi_valid,
  input  logic                  msi_ready,
  output logic [MSI_ADDR_W-1:0] msi_addr,
  output logic [MSI_DATA_W-1:0] msi_data,
  output logic                  db_err
);
  logic             ld_we;
  logic [IDX_W-1:0] ld_idx;
  msi_entry_t       ld_entry;
  logic [CNT_W-1:0] live_count;
  logic [IDX_W-1:0] slot;
  logic             hit;
  logic             rd_en;
  msi_entry_t       ram_q;
  logic             unused_payload;

  assign unused_payload = ^db_wdata;

  db_vec_loader #(.NUM_DB(NUM_DB)) u_loader (
    .clk(clk), .rst(rst), .start(cfg_start), .req_count(cfg_count),
    .shared_mode(cfg_shared), .src_addr(src_addr), .src_data(src_data),
    .src_idx(src_idx), .busy(cfg_busy), .wr_en(ld_we), .wr_idx(ld_idx),
    .wr_entry(ld_entry), .live_count(live_count)
  );

  db_vec_ram #(.DEPTH(NUM_DB)) u_ram (
    .clk(clk), .we(ld_we), .waddr(ld_idx), .wdata(ld_entry),
    .re(rd_en), .raddr(slot), .rdata(ram_q)
  );

  db_slot_decode #(.NUM_DB(NUM_DB), .OFF_W(OFF_W), .SHIFT_W(SHIFT_W)) u_dec (
    .offset(db_offset), .shift(db_slot_shift), .live_count(live_count),
    .slot(slot), .hit(hit)
  );

  db_msi_issuer u_issue (
    .clk(clk), .rst(rst), .load_busy(cfg_busy), .db_valid(db_valid), .hit(hit),
    .ram_q(ram_q), .msi_ready(msi_ready), .db_ready(db_ready), .rd_en(rd_en),
    .msi_valid(msi_valid), .msi_addr(msi_addr), .msi_data(msi_data), .db_err(db_err)
  );
endmodule

// File: tb/db_msi_gen_test.sv
`timescale 1ns/1ps
module db_msi_gen_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_start, cfg_shared, cfg_busy;
  logic [5:0]  cfg_count;
  logic [4:0]  src_idx;
  logic [63:0] src_addr, msi_addr;
  logic [31:0] src_data, msi_data, db_wdata;
  logic [3:0]  db_slot_shift;
  logic        db_valid, db_ready, msi_valid, msi_ready, db_err;
  logic [15:0] db_offset;
  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [63:0] src_a(int i);
    return 64'hFEE0_0000_0000_1000 + 64'(i) * 64'h40;
  endfunction
  function automatic logic [31:0] src_d(int i);
    return 32'h0000_4100 + 32'(i) * 32'h11;
  endfunction

  assign src_addr = src_a(int'(src_idx));
  assign src_data = src_d(int'(src_idx));

  db_msi_gen uut (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_count(cfg_count),
    .cfg_shared(cfg_shared), .cfg_busy(cfg_busy), .src_idx(src_idx),
    .src_addr(src_addr), .src_data(src_data), .db_slot_shift(db_slot_shift),
    .db_valid(db_valid), .db_ready(db_ready), .db_offset(db_offset),
    .db_wdata(db_wdata), .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_addr(msi_addr), .msi_data(msi_data), .db_err(db_err)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; cfg_start = 0; cfg_count = 0; cfg_shared = 0; db_slot_shift = 0;
    db_valid = 0; db_offset = 0; db_wdata = 0; msi_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "msi_valid", 64'(msi_valid), 0);
    chk("R1", "db_err", 64'(db_err), 0);
    chk("R1", "cfg_busy", 64'(cfg_busy), 0);
    chk("R1", "db_ready", 64'(db_ready), 1);
  endtask

  task automatic configure(int n, bit shared, int exp_busy);
    int cnt = 0;
    @(negedge clk);
    cfg_start = 1; cfg_count = 6'(n); cfg_shared = shared;
    @(negedge clk);
    cfg_start = 0;
    if (exp_busy > 0) chk("R4", "db_ready during load", 64'(db_ready), 0);
    while (cfg_busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk("R4", "busy cycles", 64'(cnt), 64'(exp_busy));
  endtask

  task automatic ring_hit(int off, logic [31:0] wd, logic [63:0] ea, logic [31:0] ed, string tag);
    @(negedge clk);
    chk(tag, "ready before", 64'(db_ready), 1);
    db_valid = 1; db_offset = 16'(off); db_wdata = wd;
    @(negedge clk);
    db_valid = 0;
    chk("R7", "ready after accept", 64'(db_ready), 0);
    chk("R6", "valid one edge after", 64'(msi_valid), 0);
    @(negedge clk);
    chk("R6", "valid two edges after", 64'(msi_valid), 1);
    chk(tag, "addr", msi_addr, ea);
    chk(tag, "data", 64'(msi_data), 64'(ed));
    @(negedge clk);
    chk("R6", "held valid", 64'(msi_valid), 1);
    chk("R6", "held addr", msi_addr, ea);
    msi_ready = 1;
    @(negedge clk);
    msi_ready = 0;
    chk("R6", "valid cleared", 64'(msi_valid), 0);
    chk("R7", "ready restored", 64'(db_ready), 1);
    @(negedge clk);
    chk("R6", "no repeat", 64'(msi_valid), 0);
  endtask

  task automatic ring_miss(int off, string tag);
    @(negedge clk);
    db_valid = 1; db_offset = 16'(off); db_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    db_valid = 0;
    chk(tag, "err set", 64'(db_err), 1);
    chk(tag, "ready kept", 64'(db_ready), 1);
    @(negedge clk);
    chk(tag, "no request", 64'(msi_valid), 0);
    @(negedge clk);
    chk(tag, "no late request", 64'(msi_valid), 0);
  endtask

  task automatic t_unconfigured();
    do_reset();
    ring_miss(0, "R5");
    repeat (4) @(negedge clk);
    chk("R5", "err sticky", 64'(db_err), 1);
  endtask

  task automatic t_per_vector();
    do_reset();
    db_slot_shift = 3;
    configure(8, 0, 8);
    chk("R5", "no err after config", 64'(db_err), 0);
    ring_hit(40, 32'h0, src_a(5), src_d(5), "R2");
    ring_hit(63, 32'h0, src_a(7), src_d(7), "R2");
    ring_hit(0, 32'h0, src_a(0), src_d(0), "R2");
    ring_hit(16, 32'h0, src_a(2), src_d(2), "R8");
    ring_hit(16, 32'hFFFF_FFFF, src_a(2), src_d(2), "R8");
    db_slot_shift = 5;
    ring_hit(96, 32'h1234, src_a(3), src_d(3), "R10");
    chk("R5", "err clear before miss", 64'(db_err), 0);
    ring_miss(256, "R5");
  endtask

  task automatic t_shared();
    configure(40, 1, 32);
    db_slot_shift = 2;
    ring_hit(124, 32'h0, src_a(0), src_d(0) + 32'd31, "R3");
    ring_hit(8, 32'h0, src_a(0), src_d(0) + 32'd2, "R3");
  endtask

  task automatic t_shrink();
    configure(4, 0, 4);
    ring_miss(20, "R9");
    ring_hit(12, 32'h0, src_a(3), src_d(3), "R9");
    configure(0, 0, 0);
    ring_miss(0, "R5");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_unconfigured();
    t_per_vector();
    t_shared();
    t_shrink();
    finish_run();
  end
endmodule